// File: doc/BRIEF.md
# Cache Maintenance Range Splitter

This block converts one high-level cache maintenance request into the ordered stream of commands that a downstream range walker executes. A request names an operation (invalidate, clean or flush), a byte start address and an exclusive byte end address. The block trims partial lines at the ends of an invalidate, rounds the span of a clean or flush out to whole lines, and cuts the remaining span into chunks. No chunk exceeds the byte cap or crosses a page boundary. Each range command carries an inclusive end that names the base of the last line it covers.

A write-through override input is sampled with the request. When it is set, the cache holds no dirty data, so clean work is dropped. Requests enter through a valid/ready handshake that is ready only while the block is idle. Commands leave through a second valid/ready handshake. A one-cycle `done` pulse marks the end of each request.

Encodings: `req_op` 0 = invalidate, 1 = clean, 2 = flush. `cmd_kind` 0 = single-line clean-and-invalidate, 1 = range clean, 2 = range invalidate. Defaults are 32-byte lines, a 1024-byte cap per command and 4 KB pages.

Top module: `maint_splitter`

## Requirements
- R1: The inclusive end of a range command equals its exclusive chunk end minus one line (32 bytes). Both `cmd_start` and `cmd_end` are line-aligned. A single-line command carries the line base in both fields.
- R2: A range command covers at most 1024 bytes, so `cmd_end - cmd_start` is at most 992.
- R3: The chunk end is the smallest of three values: the body end, start plus 1024, and the next 4 KB boundary. `cmd_start` and `cmd_end` therefore lie in the same page.
- R4: For an invalidate whose start is not line-aligned, the first command is a single-line clean-and-invalidate (kind 0) on the line holding the start. The body then begins at the next line boundary.
- R5: For an invalidate, if the advanced start is still below the end and the end is not line-aligned, a kind 0 command on the line holding the end follows the head. The body end is then rounded down to a line boundary.
- R6: For an invalidate, the remaining full lines are covered in ascending chunks by range-invalidate commands (kind 2). There are none when the body is empty.
- R7: For a clean or a flush, the start is rounded down and the end is rounded up to line boundaries before chunking.
- R8: With the override set, a clean emits no command and only pulses `done`. A flush emits only the range-invalidate commands.
- R9: Without the override, each flush chunk emits a range clean (kind 1) followed by a range invalidate (kind 2) over the same inclusive range.
- R10: `req_ready` is high only when idle. A command held with `cmd_ready` low stays stable. `done` is a single-cycle pulse one cycle after the last command is accepted, or one cycle after the request when no command is emitted. It never coincides with `cmd_valid`.
- R11: `align_err` rises only if a chunk boundary presented to the walker is not line-aligned. It stays low for every legal request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle, request accepted this cycle if valid |
| req_op | input | 2 | 0 invalidate, 1 clean, 2 flush |
| req_start | input | AW | First byte address |
| req_end | input | AW | Exclusive end byte address |
| wt_override | input | 1 | Write-through override, sampled with the request |
| cmd_valid | output | 1 | Command offered to the walker |
| cmd_ready | input | 1 | Walker accepts the command |
| cmd_kind | output | 2 | 0 line clean-and-invalidate, 1 range clean, 2 range invalidate |
| cmd_start | output | AW | Line-aligned first line address |
| cmd_end | output | AW | Line-aligned inclusive last line address |
| done | output | 1 | One-cycle pulse, request finished |
| align_err | output | 1 | Misaligned chunk boundary detected |

## Verification
The assertions assume the following about every request: the start is no greater than the end, the end rounded up to a line stays below the top of the address space, and `req_op` never takes the value 3. Under those assumptions the properties hold: a stalled command stays stable, every command stays aligned, within one page and within the byte cap, and `done` stays exclusive of command traffic. The stimulus respects the same assumptions. Random requests draw a start below 1 MB and a length below about 6 KB. The directed cases cover zero-length spans, spans inside a single line, page crossings and spans longer than several caps.

// File: rtl/maint_pkg.sv
// Shared encodings for the maintenance range splitter.
package maint_pkg;
    typedef enum logic [1:0] {
        OP_INV   = 2'd0,
        OP_CLEAN = 2'd1,
        OP_FLUSH = 2'd2
    } op_e;

    typedef enum logic [1:0] {
        CMD_LINE_CI     = 2'd0,
        CMD_RANGE_CLEAN = 2'd1,
        CMD_RANGE_INV   = 2'd2
    } cmd_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HEAD,
        ST_TAIL,
        ST_CHUNK_A,
        ST_CHUNK_B,
        ST_DONE
    } st_e;
endpackage

// File: rtl/maint_edge_prep.sv
// Edge preparation: from a raw request, derives the single-line edge
// operations (invalidate only) and the line-aligned body span [lo, hi).
// Assumes start <= end and that end rounded up does not wrap.
module maint_edge_prep
    import maint_pkg::*;
#(
    parameter int AW         = 32,
    parameter int LINE_BYTES = 32
) (
    input  op_e           op,
    input  logic [AW-1:0] raw_start,
    input  logic [AW-1:0] raw_end,
    output logic          head_en,
    output logic [AW-1:0] head_line,
    output logic          tail_en,
    output logic [AW-1:0] tail_line,
    output logic [AW-1:0] body_lo,
    output logic [AW-1:0] body_hi
);
    localparam int LW = $clog2(LINE_BYTES);
    localparam logic [AW-1:0] LINE = AW'(LINE_BYTES);

    logic [AW-1:0] start_dn, start_up, end_dn, end_up, s_adv;
    logic          start_part, end_part;

    // Line rounding of both request addresses.
    always_comb begin
        start_dn   = {raw_start[AW-1:LW], {LW{1'b0}}};
        end_dn     = {raw_end[AW-1:LW], {LW{1'b0}}};
        start_part = (raw_start[LW-1:0] != '0);
        end_part   = (raw_end[LW-1:0] != '0);
        start_up   = start_dn + LINE;
        end_up     = end_part ? (end_dn + LINE) : end_dn;
        s_adv      = start_part ? start_up : raw_start;
    end

    // Edge and body selection by operation type.
    always_comb begin
        head_line = start_dn;
        tail_line = end_dn;
        if (op == OP_INV) begin
            head_en = start_part;
            tail_en = (s_adv < raw_end) && end_part;
            body_lo = s_adv;
            body_hi = tail_en ? end_dn : raw_end;
        end else begin
            head_en = 1'b0;
            tail_en = 1'b0;
            body_lo = start_dn;
            body_hi = end_up;
        end
    end
endmodule

// File: rtl/maint_chunk_calc.sv
// Chunk limiter: exclusive end of the chunk beginning at cur, bounded by
// the body end, the byte cap and the next page boundary.
// Assumes cur < hi and both are line-aligned.
module maint_chunk_calc #(
    parameter int AW         = 32,
    parameter int MAX_BYTES  = 1024,
    parameter int PAGE_BYTES = 4096
) (
    input  logic [AW-1:0] cur,
    input  logic [AW-1:0] hi,
    output logic [AW-1:0] nxt
);
    logic [AW:0] cap_x, page_x, pick;

    // Minimum of the three candidate bounds, computed one bit wider.
    always_comb begin
        cap_x  = {1'b0, cur} + (AW+1)'(MAX_BYTES);
        page_x = ({1'b0, cur} | (AW+1)'(PAGE_BYTES - 1)) + (AW+1)'(1);
        pick   = {1'b0, hi};
        if (cap_x < pick)  pick = cap_x;
        if (page_x < pick) pick = page_x;
        nxt = pick[AW-1:0];
    end
endmodule

// File: rtl/maint_splitter.sv
// Maintenance range splitter: accepts one request at a time and emits the
// edge line commands, then per-chunk range commands, then pulses done.
// Assumes start <= end and req_op in {0,1,2}; wt_override is sampled
// together with the request.
module maint_splitter
    import maint_pkg::*;
#(
    parameter int AW         = 32,
    parameter int LINE_BYTES = 32,
    parameter int MAX_BYTES  = 1024,
    parameter int PAGE_BYTES = 4096
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [1:0]    req_op,
    input  logic [AW-1:0] req_start,
    input  logic [AW-1:0] req_end,
    input  logic          wt_override,
    output logic          cmd_valid,
    input  logic          cmd_ready,
    output logic [1:0]    cmd_kind,
    output logic [AW-1:0] cmd_start,
    output logic [AW-1:0] cmd_end,
    output logic          done,
    output logic          align_err
);
    localparam int LW = $clog2(LINE_BYTES);
    localparam logic [AW-1:0] LINE = AW'(LINE_BYTES);

    st_e           state;
    op_e           op_q;
    logic          wt_q, tail_en_q;
    logic [AW-1:0] head_q, tail_q, cur_q, hi_q;

    op_e           op_in;
    logic          p_head_en, p_tail_en;
    logic [AW-1:0] p_head, p_tail, p_lo, p_hi, chunk_nxt;
    logic          take_req, take_cmd, pair_first;

    assign op_in = op_e'(req_op);

    maint_edge_prep #(.AW(AW), .LINE_BYTES(LINE_BYTES)) u_prep (
        .op        (op_in),
        .raw_start (req_start),
        .raw_end   (req_end),
        .head_en   (p_head_en),
        .head_line (p_head),
        .tail_en   (p_tail_en),
        .tail_line (p_tail),
        .body_lo   (p_lo),
        .body_hi   (p_hi)
    );

    maint_chunk_calc #(.AW(AW), .MAX_BYTES(MAX_BYTES), .PAGE_BYTES(PAGE_BYTES)) u_chunk (
        .cur (cur_q),
        .hi  (hi_q),
        .nxt (chunk_nxt)
    );

    // Body entry: the span is non-empty and not a clean under override.
    function automatic st_e body_or_done(input logic [AW-1:0] lo, input logic [AW-1:0] hi,
                                         input op_e op, input logic wt);
        return ((lo < hi) && !(op == OP_CLEAN && wt)) ? ST_CHUNK_A : ST_DONE;
    endfunction

    // Handshake qualifiers.
    always_comb begin
        req_ready  = (state == ST_IDLE);
        cmd_valid  = (state == ST_HEAD) || (state == ST_TAIL) ||
                     (state == ST_CHUNK_A) || (state == ST_CHUNK_B);
        done       = (state == ST_DONE);
        take_req   = req_valid && req_ready;
        take_cmd   = cmd_valid && cmd_ready;
        pair_first = (op_q == OP_FLUSH) && !wt_q;
    end

    // Command fields for the current state.
    always_comb begin
        cmd_kind  = CMD_RANGE_INV;
        cmd_start = cur_q;
        cmd_end   = chunk_nxt - LINE;
        case (state)
            ST_HEAD: begin
                cmd_kind  = CMD_LINE_CI;
                cmd_start = head_q;
                cmd_end   = head_q;
            end
            ST_TAIL: begin
                cmd_kind  = CMD_LINE_CI;
                cmd_start = tail_q;
                cmd_end   = tail_q;
            end
            ST_CHUNK_A: begin
                if (op_q == OP_CLEAN || pair_first) cmd_kind = CMD_RANGE_CLEAN;
            end
            default: cmd_kind = CMD_RANGE_INV;
        endcase
    end

    // Sanity flag on chunk boundaries handed to the walker.
    always_comb begin
        align_err = ((state == ST_CHUNK_A) || (state == ST_CHUNK_B)) &&
                    ((cur_q[LW-1:0] != '0) || (chunk_nxt[LW-1:0] != '0));
    end

    // Sequencer: request capture, edge lines, chunk walk, done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            op_q      <= OP_INV;
            wt_q      <= 1'b0;
            tail_en_q <= 1'b0;
            head_q    <= '0;
            tail_q    <= '0;
            cur_q     <= '0;
            hi_q      <= '0;
        end else begin
            case (state)
                ST_IDLE: if (take_req) begin
                    op_q      <= op_in;
                    wt_q      <= wt_override;
                    tail_en_q <= p_tail_en;
                    head_q    <= p_head;
                    tail_q    <= p_tail;
                    cur_q     <= p_lo;
                    hi_q      <= p_hi;
                    if (p_head_en)      state <= ST_HEAD;
                    else if (p_tail_en) state <= ST_TAIL;
                    else                state <= body_or_done(p_lo, p_hi, op_in, wt_override);
                end
                ST_HEAD: if (take_cmd) begin
                    if (tail_en_q) state <= ST_TAIL;
                    else           state <= body_or_done(cur_q, hi_q, op_q, wt_q);
                end
                ST_TAIL: if (take_cmd) begin
                    state <= body_or_done(cur_q, hi_q, op_q, wt_q);
                end
                ST_CHUNK_A: if (take_cmd) begin
                    if (pair_first) begin
                        state <= ST_CHUNK_B;
                    end else begin
                        cur_q <= chunk_nxt;
                        state <= (chunk_nxt >= hi_q) ? ST_DONE : ST_CHUNK_A;
                    end
                end
                ST_CHUNK_B: if (take_cmd) begin
                    cur_q <= chunk_nxt;
                    state <= (chunk_nxt >= hi_q) ? ST_DONE : ST_CHUNK_A;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/maint_splitter_chk.sv
// Property checker for the splitter, attached by bind below.
// Assumes legal requests (start <= end, op in {0,1,2}).
module maint_splitter_chk #(
    parameter int AW         = 32,
    parameter int LINE_BYTES = 32,
    parameter int MAX_BYTES  = 1024,
    parameter int PAGE_BYTES = 4096
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_ready,
    input logic          cmd_valid,
    input logic          cmd_ready,
    input logic [1:0]    cmd_kind,
    input logic [AW-1:0] cmd_start,
    input logic [AW-1:0] cmd_end,
    input logic          done,
    input logic          align_err
);
    localparam int LW = $clog2(LINE_BYTES);
    localparam int PW = $clog2(PAGE_BYTES);

    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_kind) &&
                                    $stable(cmd_start) && $stable(cmd_end));

    a_r1_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> (cmd_start[LW-1:0] == '0) && (cmd_end[LW-1:0] == '0) &&
                      (cmd_end >= cmd_start));

    a_r2_cap: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> (cmd_end - cmd_start) <= AW'(MAX_BYTES - LINE_BYTES));

    a_r3_one_page: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> cmd_start[AW-1:PW] == cmd_end[AW-1:PW]);

    a_r10_done_alone: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !cmd_valid && !req_ready);

    a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r11_no_err: assert property (@(posedge clk) disable iff (!rst_n)
        !align_err);
endmodule

bind maint_splitter maint_splitter_chk #(
    .AW(AW), .LINE_BYTES(LINE_BYTES), .MAX_BYTES(MAX_BYTES), .PAGE_BYTES(PAGE_BYTES)
) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_ready (req_ready),
    .cmd_valid (cmd_valid),
    .cmd_ready (cmd_ready),
    .cmd_kind  (cmd_kind),
    .cmd_start (cmd_start),
    .cmd_end   (cmd_end),
    .done      (done),
    .align_err (align_err)
);

// File: tb/test_maint_splitter.sv
`timescale 1ns/1ps
module test_maint_splitter;
    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [1:0]    req_op = 2'd0;
    logic [AW-1:0] req_start = '0;
    logic [AW-1:0] req_end = '0;
    logic          wt_override = 1'b0;
    logic          cmd_valid;
    logic          cmd_ready = 1'b0;
    logic [1:0]    cmd_kind;
    logic [AW-1:0] cmd_start;
    logic [AW-1:0] cmd_end;
    logic          done;
    logic          align_err;

    int checks = 0;
    int fails  = 0;

    logic [1:0]  exp_kind [512];
    logic [31:0] exp_s    [512];
    logic [31:0] exp_e    [512];
    int          exp_n;

    always #4 clk = ~clk;

    maint_splitter i_maint_splitter (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_start(req_start), .req_end(req_end),
        .wt_override(wt_override), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_kind(cmd_kind), .cmd_start(cmd_start), .cmd_end(cmd_end),
        .done(done), .align_err(align_err)
    );

    task automatic chk(input logic ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, expv);
        end
    endtask

    task automatic push(input logic [1:0] k, input logic [31:0] s, input logic [31:0] e);
        exp_kind[exp_n] = k;
        exp_s[exp_n]    = s;
        exp_e[exp_n]    = e;
        exp_n++;
    endtask

    // Expected command list built from the requirements.
    task automatic build(input logic [1:0] op, input logic [31:0] s, input logic [31:0] e,
                         input logic wt);
        logic [31:0] lo, hi, ce;
        exp_n = 0;
        if (op == 2'd0) begin
            lo = s;
            hi = e;
            if (lo % 32 != 0) begin
                push(2'd0, lo & ~32'd31, lo & ~32'd31);
                lo = (lo & ~32'd31) + 32;
            end
            if (lo < hi && hi % 32 != 0) begin
                push(2'd0, hi & ~32'd31, hi & ~32'd31);
                hi = hi & ~32'd31;
            end
        end else begin
            lo = s & ~32'd31;
            hi = (e + 31) & ~32'd31;
        end
        if (op == 2'd1 && wt) return;
        while (lo < hi) begin
            ce = hi;
            if (lo + 1024 < ce) ce = lo + 1024;
            if ((lo / 4096 + 1) * 4096 < ce) ce = (lo / 4096 + 1) * 4096;
            if (op == 2'd0)      push(2'd2, lo, ce - 32);
            else if (op == 2'd1) push(2'd1, lo, ce - 32);
            else begin
                if (!wt) push(2'd1, lo, ce - 32);
                push(2'd2, lo, ce - 32);
            end
            lo = ce;
        end
    endtask

    task automatic run_req(input logic [1:0] op, input logic [31:0] s, input logic [31:0] e,
                           input logic wt, input string tag);
        int idx = 0;
        int cyc = 0;
        logic err_seen = 1'b0;
        build(op, s, e, wt);
        @(negedge clk);
        chk(req_ready === 1'b1 && done === 1'b0, "R10", "idle before request", {30'd0, req_ready, done}, 32'd2);
        req_op = op; req_start = s; req_end = e; wt_override = wt; req_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        while (1) begin
            if (align_err) err_seen = 1'b1;
            if (done) break;
            if (cyc > 3000) begin
                chk(1'b0, tag, "watchdog per request", 32'(cyc), 32'd0);
                break;
            end
            cmd_ready = ($urandom % 4) != 0;
            if (cmd_valid && cmd_ready) begin
                if (idx < exp_n) begin
                    chk(cmd_kind == exp_kind[idx], tag, "kind", {30'd0, cmd_kind}, {30'd0, exp_kind[idx]});
                    chk(cmd_start == exp_s[idx], tag, "start", cmd_start, exp_s[idx]);
                    chk(cmd_end == exp_e[idx], (exp_kind[idx] == 2'd0) ? tag : "R1", "inclusive end", cmd_end, exp_e[idx]);
                    chk(cmd_end - cmd_start <= 32'd992, "R2", "cap", cmd_end - cmd_start, 32'd992);
                    chk(cmd_start[31:12] == cmd_end[31:12], "R3", "page", cmd_end, cmd_start);
                end else begin
                    chk(1'b0, tag, "extra command", cmd_start, 32'(exp_n));
                end
                idx++;
            end
            @(posedge clk);
            @(negedge clk);
            cyc++;
        end
        cmd_ready = 1'b0;
        chk(idx == exp_n, "R10", "commands before done", 32'(idx), 32'(exp_n));
        chk(!err_seen, "R11", "align_err", {31'd0, err_seen}, 32'd0);
        @(negedge clk);
        chk(done === 1'b0, "R10", "done single pulse", {31'd0, done}, 32'd0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog global actual=expired expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(req_ready === 1'b0 || 1'b1, "R10", "reset", 32'd0, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(cmd_valid === 1'b0 && done === 1'b0 && req_ready === 1'b1, "R10", "reset state",
            {29'd0, cmd_valid, done, req_ready}, 32'd1);

        run_req(2'd0, 32'h1000, 32'h1100, 1'b0, "R6");
        run_req(2'd0, 32'h2005, 32'h2011, 1'b0, "R4");
        run_req(2'd0, 32'h2005, 32'h2091, 1'b0, "R5");
        run_req(2'd0, 32'h2040, 32'h2055, 1'b0, "R5");
        run_req(2'd0, 32'h0F00, 32'h1200, 1'b0, "R3");
        run_req(2'd0, 32'h3000, 32'h3000, 1'b0, "R6");
        run_req(2'd1, 32'h4010, 32'h4031, 1'b0, "R7");
        run_req(2'd1, 32'h4000, 32'h6000, 1'b1, "R8");
        run_req(2'd1, 32'h5000, 32'h5000, 1'b0, "R7");
        run_req(2'd2, 32'h0E11, 32'h2345, 1'b0, "R9");
        run_req(2'd2, 32'h0E11, 32'h2345, 1'b1, "R8");
        run_req(2'd1, 32'h7C00, 32'h9000, 1'b0, "R2");

        for (int i = 0; i < 80; i++) begin
            logic [1:0]  op;
            logic [31:0] s, len;
            op  = 2'($urandom % 3);
            s   = $urandom % 32'h0010_0000;
            len = $urandom % 6000;
            if (i % 7 == 0) len = len % 40;
            run_req(op, s, s + len, 1'($urandom % 2),
                    (op == 2'd0) ? "R6" : (op == 2'd1) ? "R7" : "R9");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule